// File: doc/BRIEF.md
# Parallel Printer Port Register Controller

This block is a byte-wide parallel printer port that sits on a simple host register bus. Software sees three registers: an output/input data register, a printer status register and a port control register. An integrated printer responder answers the strobe/busy/acknowledge handshake by itself, so a driver can be brought up and exercised with no printer attached. Every completed strobe hands the current output byte to a byte stream output, marked by a single-cycle valid pulse.

The status register is partly driven by reads: a qualifying status read walks the responder through its acknowledge and busy phases, the same way a polling driver would see a slow printer answer. A falling acknowledge can raise an interrupt when software has enabled it. The data pins are driven from the output latch while the direction bit is clear; with the direction bit set, the pin value is captured into an input latch and read back instead.

Top module: `lpt_port_ctrl`

## Requirements
- R1: After reset, status reads 0xD9 with the paper-out input low (busy bit 7, acknowledge bit 6, online bit 4, error bit 3 and timeout bit 0 set), control reads 0x0C (select-in bit 3 and init bit 2 set), the data register reads 0x00, and irq and prn_valid are low.
- R2: A write to offset 0 loads the output latch, which drives pin_dout and reads back at offset 0 while control bit 5 (direction) is 0; a write to offset 2 loads control bits 5:0, which read back at offset 2 with bits 7:6 reading 0; pin_dout_en equals the inverse of the direction bit.
- R3: With direction set, a read of offset 0 returns the value pin_din held at the previous clock edge.
- R4: A control write with bit 2 (init) clear forces status bits busy, acknowledge, online and error to 1 and timeout to 0.
- R5: A control write with init, select-in (bit 3) and strobe (bit 0) all set clears busy; if strobe was 0 in the control register before that write, prn_byte carries the output latch and prn_valid is high for exactly the cycle after the write.
- R6: A control write with init set but select-in or strobe clear emits no byte and leaves busy unchanged.
- R7: A status read while busy is 0 and control strobe is 0 clears acknowledge if it was 1; otherwise it sets both acknowledge and busy.
- R8: A status read while busy is 1 or control strobe is 1 leaves status unchanged.
- R9: irq rises the cycle after acknowledge falls while control bit 4 (interrupt enable) is 1, and drops after a status read that does not itself clear acknowledge, or as soon as interrupt enable is written to 0.
- R10: Writes to offset 1 and offsets 3 to 7 change no register; reads of offsets 3 to 7 return 0xFF.
- R11: Status bit 5 reads the paper_out_in input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_sel | input | 1 | Register access this cycle |
| bus_we | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 3 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid in the access cycle |
| pin_din | input | 8 | Data pins as seen from the cable |
| pin_dout | output | 8 | Output latch towards the cable |
| pin_dout_en | output | 1 | Drive enable for the data pins |
| pin_ctl | output | 4 | Control bits 3:0 towards the cable |
| paper_out_in | input | 1 | Static paper-out condition |
| prn_byte | output | 8 | Byte taken by the responder |
| prn_valid | output | 1 | One-cycle valid for prn_byte |
| irq | output | 1 | Interrupt request |

## Verification
A wrong internal state surfaces at the next status read, because the read value exposes busy and acknowledge directly and every read also advances them; a single missed or doubled handshake step therefore shows within one poll. A wrong stored strobe value shows as a missing or extra prn_valid pulse on the cycle after the next strobe write, and a wrong interrupt-enable or acknowledge history shows on irq one cycle after the read that should or should not have raised it. The bench keeps a cycle-level reference of every register and compares each read, irq and prn_valid on every cycle, so divergence is caught in the cycle it reaches the ports.

// File: rtl/lpt_pkg.sv
package lpt_pkg;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = 3;
  localparam int CTL_W  = 6;

  localparam logic [ADDR_W-1:0] OFS_DATA = 3'd0;
  localparam logic [ADDR_W-1:0] OFS_STAT = 3'd1;
  localparam logic [ADDR_W-1:0] OFS_CTRL = 3'd2;

  localparam int ST_BUSY   = 7;
  localparam int ST_ACK    = 6;
  localparam int ST_PAPER  = 5;
  localparam int ST_ONLINE = 4;
  localparam int ST_ERROR  = 3;
  localparam int ST_TMO    = 0;

  localparam int CT_DIR  = 5;
  localparam int CT_IEN  = 4;
  localparam int CT_SEL  = 3;
  localparam int CT_INIT = 2;
  localparam int CT_ALF  = 1;
  localparam int CT_STB  = 0;

  localparam logic [CTL_W-1:0]  CTL_RST  = 6'h0C;
  localparam logic [BYTE_W-1:0] IDLE_RD  = 8'hFF;

  typedef struct packed {
    logic wr_data;
    logic wr_ctrl;
    logic rd_data;
    logic rd_stat;
    logic rd_ctrl;
    logic rd_unused;
  } lpt_hit_t;

  typedef struct packed {
    logic busy;
    logic ack;
    logic online;
    logic error;
    logic tmo;
  } lpt_stat_t;

  function automatic logic [BYTE_W-1:0] pack_status(lpt_stat_t s, logic paper);
    logic [BYTE_W-1:0] v;
    v            = '0;
    v[ST_BUSY]   = s.busy;
    v[ST_ACK]    = s.ack;
    v[ST_PAPER]  = paper;
    v[ST_ONLINE] = s.online;
    v[ST_ERROR]  = s.error;
    v[ST_TMO]    = s.tmo;
    return v;
  endfunction
endpackage

// File: rtl/lpt_rst_sync.sv
module lpt_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  localparam int NS = (STAGES < 2) ? 2 : STAGES;

  logic [NS-1:0] sync_q;
  logic [NS-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[NS-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_n_out = sync_q[NS-1];
endmodule

// File: rtl/lpt_reg_decode.sv
module lpt_reg_decode
  import lpt_pkg::*;
#(
  parameter int AW = ADDR_W
) (
  input  logic          sel,
  input  logic          we,
  input  logic [AW-1:0] addr,
  output lpt_hit_t      hit
);
  logic is_data, is_stat, is_ctrl;

  always_comb begin
    is_data = (addr == AW'(OFS_DATA));
    is_stat = (addr == AW'(OFS_STAT));
    is_ctrl = (addr == AW'(OFS_CTRL));

    hit           = '0;
    hit.wr_data   = sel &  we & is_data;
    hit.wr_ctrl   = sel &  we & is_ctrl;
    hit.rd_data   = sel & ~we & is_data;
    hit.rd_stat   = sel & ~we & is_stat;
    hit.rd_ctrl   = sel & ~we & is_ctrl;
    hit.rd_unused = sel & ~we & ~(is_data | is_stat | is_ctrl);
  end
endmodule

// File: rtl/lpt_printer_seq.sv
module lpt_printer_seq
  import lpt_pkg::*;
#(
  parameter int DW = BYTE_W,
  parameter int CW = CTL_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ctrl_wr,
  input  logic [DW-1:0] wdata,
  input  logic [CW-1:0] ctl_q,
  input  logic [DW-1:0] data_q,
  input  logic          rd_stat,
  output lpt_stat_t     stat_q,
  output logic [DW-1:0] byte_q,
  output logic          valid_q,
  output logic          ack_fall
);
  lpt_stat_t     stat_d;
  logic [DW-1:0] byte_d;
  logic          valid_d;
  logic          stat_en;
  logic          byte_en;
  logic          poll_ok;
  logic          init_req;
  logic          strobe_req;

  always_comb begin
    init_req   = ctrl_wr & ~wdata[CT_INIT];
    strobe_req = ctrl_wr &  wdata[CT_INIT] & wdata[CT_SEL] & wdata[CT_STB];
    poll_ok    = ~ctrl_wr & rd_stat & ~stat_q.busy & ~ctl_q[CT_STB];

    stat_d   = stat_q;
    byte_d   = byte_q;
    valid_d  = 1'b0;
    ack_fall = 1'b0;
    stat_en  = 1'b0;
    byte_en  = 1'b0;

    if (init_req) begin
      stat_en       = 1'b1;
      stat_d.busy   = 1'b1;
      stat_d.ack    = 1'b1;
      stat_d.online = 1'b1;
      stat_d.error  = 1'b1;
      stat_d.tmo    = 1'b0;
    end else if (strobe_req) begin
      stat_en     = 1'b1;
      stat_d.busy = 1'b0;
      if (!ctl_q[CT_STB]) begin
        valid_d = 1'b1;
        byte_en = 1'b1;
        byte_d  = data_q;
      end
    end else if (poll_ok) begin
      stat_en = 1'b1;
      if (stat_q.ack) begin
        stat_d.ack = 1'b0;
        ack_fall   = 1'b1;
      end else begin
        stat_d.ack  = 1'b1;
        stat_d.busy = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q.busy   <= 1'b1;
      stat_q.ack    <= 1'b1;
      stat_q.online <= 1'b1;
      stat_q.error  <= 1'b1;
      stat_q.tmo    <= 1'b1;
    end else if (stat_en) begin
      stat_q <= stat_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      byte_q <= '0;
    end else if (byte_en) begin
      byte_q <= byte_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
    end else begin
      valid_q <= valid_d;
    end
  end

  AST_INIT_FORCES_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && !wdata[CT_INIT]) |=> (stat_q.busy && stat_q.ack && stat_q.online && stat_q.error && !stat_q.tmo)); // R4
  AST_STROBE_DROPS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && wdata[CT_INIT] && wdata[CT_SEL] && wdata[CT_STB]) |=> !stat_q.busy); // R5
  AST_EMIT_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && wdata[CT_INIT] && wdata[CT_SEL] && wdata[CT_STB] && !ctl_q[CT_STB]) |=> (valid_q && byte_q == $past(data_q))); // R5
  AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q |=> !valid_q); // R5
  AST_NO_EMIT_WITHOUT_SEL: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && !wdata[CT_SEL]) |=> !valid_q); // R6
  AST_ACK_FALL_FROM_POLL: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(stat_q.ack) |-> $past(rd_stat)); // R7
  AST_BUSY_POLL_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stat && !ctrl_wr && (stat_q.busy || ctl_q[CT_STB])) |=> $stable(stat_q)); // R8
endmodule

// File: rtl/lpt_irq_gen.sv
module lpt_irq_gen (
  input  logic clk,
  input  logic rst_n,
  input  logic ack_fall,
  input  logic ien_q,
  input  logic ien_d,
  input  logic rd_stat,
  output logic irq_q
);
  logic irq_d;

  always_comb begin
    irq_d = irq_q;
    if (ack_fall && ien_q) begin
      irq_d = 1'b1;
    end else if (rd_stat || !ien_d) begin
      irq_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q <= 1'b0;
    end else begin
      irq_q <= irq_d;
    end
  end

  AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |-> ien_q); // R9
  AST_IRQ_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_fall && ien_q) |=> irq_q); // R9
  AST_IRQ_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stat && !ack_fall) |=> !irq_q); // R9
endmodule

// File: rtl/lpt_port_ctrl.sv
module lpt_port_ctrl
  import lpt_pkg::*;
#(
  parameter int DW          = BYTE_W,
  parameter int AW          = ADDR_W,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_sel,
  input  logic          bus_we,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic [DW-1:0] pin_din,
  output logic [DW-1:0] pin_dout,
  output logic          pin_dout_en,
  output logic [3:0]    pin_ctl,
  input  logic          paper_out_in,
  output logic [DW-1:0] prn_byte,
  output logic          prn_valid,
  output logic          irq
);
  localparam int CW = CTL_W;

  logic          rst_n_s;
  lpt_hit_t      hit;
  logic [DW-1:0] data_q, data_d;
  logic [DW-1:0] din_q, din_d;
  logic [CW-1:0] ctl_q, ctl_d;
  logic          data_en, din_en, ctl_en;
  lpt_stat_t     stat_q;
  logic          ack_fall;

  lpt_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_n_s)
  );

  lpt_reg_decode #(.AW(AW)) u_decode (
    .sel  (bus_sel),
    .we   (bus_we),
    .addr (bus_addr),
    .hit  (hit)
  );

  always_comb begin
    data_en = hit.wr_data;
    data_d  = bus_wdata;
    ctl_en  = hit.wr_ctrl;
    ctl_d   = ctl_en ? bus_wdata[CW-1:0] : ctl_q;
    din_en  = ctl_q[CT_DIR];
    din_d   = pin_din;
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      data_q <= '0;
    end else if (data_en) begin
      data_q <= data_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      ctl_q <= CTL_RST;
    end else if (ctl_en) begin
      ctl_q <= ctl_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      din_q <= '0;
    end else if (din_en) begin
      din_q <= din_d;
    end
  end

  lpt_printer_seq #(.DW(DW), .CW(CW)) u_printer (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .ctrl_wr  (hit.wr_ctrl),
    .wdata    (bus_wdata),
    .ctl_q    (ctl_q),
    .data_q   (data_q),
    .rd_stat  (hit.rd_stat),
    .stat_q   (stat_q),
    .byte_q   (prn_byte),
    .valid_q  (prn_valid),
    .ack_fall (ack_fall)
  );

  lpt_irq_gen u_irq (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .ack_fall (ack_fall),
    .ien_q    (ctl_q[CT_IEN]),
    .ien_d    (ctl_d[CT_IEN]),
    .rd_stat  (hit.rd_stat),
    .irq_q    (irq)
  );

  always_comb begin
    bus_rdata = '0;
    unique case (1'b1)
      hit.rd_data:   bus_rdata = ctl_q[CT_DIR] ? din_q : data_q;
      hit.rd_stat:   bus_rdata = pack_status(stat_q, paper_out_in);
      hit.rd_ctrl:   bus_rdata = {{(DW-CW){1'b0}}, ctl_q};
      hit.rd_unused: bus_rdata = IDLE_RD;
      default:       bus_rdata = '0;
    endcase
  end

  assign pin_dout    = data_q;
  assign pin_dout_en = ~ctl_q[CT_DIR];
  assign pin_ctl     = ctl_q[3:0];

  AST_CTL_ONLY_BY_OFS2: assert property (@(posedge clk) disable iff (!rst_n_s)
    !hit.wr_ctrl |=> $stable(ctl_q)); // R10
  AST_DATA_ONLY_BY_OFS0: assert property (@(posedge clk) disable iff (!rst_n_s)
    !hit.wr_data |=> $stable(data_q)); // R10
  AST_DATA_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n_s)
    hit.wr_data |=> (pin_dout == $past(bus_wdata))); // R2
endmodule

// File: tb/lpt_port_ctrl_tb.sv
module lpt_port_ctrl_tb;
  localparam int  CLK_PERIOD = 10;
  localparam int  N_RANDOM   = 4000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_sel = 1'b0;
  logic       bus_we = 1'b0;
  logic [2:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic [7:0] pin_din = '0;
  logic [7:0] pin_dout;
  logic       pin_dout_en;
  logic [3:0] pin_ctl;
  logic       paper_out_in = 1'b0;
  logic [7:0] prn_byte;
  logic       prn_valid;
  logic       irq;

  int n_checks = 0;
  int n_fail   = 0;

  // reference state
  logic [7:0] m_data, m_din, m_byte;
  logic [5:0] m_ctl;
  logic m_busy, m_ack, m_onl, m_err, m_tmo, m_irq, m_valid;

  always #(CLK_PERIOD/2) clk = ~clk;

  lpt_port_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_din(pin_din), .pin_dout(pin_dout), .pin_dout_en(pin_dout_en),
    .pin_ctl(pin_ctl), .paper_out_in(paper_out_in), .prn_byte(prn_byte),
    .prn_valid(prn_valid), .irq(irq)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_status();
    return {m_busy, m_ack, paper_out_in, m_onl, m_err, 2'b00, m_tmo};
  endfunction

  function automatic logic [7:0] exp_read(input logic [2:0] a);
    case (a)
      3'd0:    return m_ctl[5] ? m_din : m_data;
      3'd1:    return exp_status();
      3'd2:    return {2'b00, m_ctl};
      default: return 8'hFF;
    endcase
  endfunction

  function automatic string def_tag(input logic [2:0] a);
    case (a)
      3'd0:    return m_ctl[5] ? "R3" : "R2";
      3'd1:    return "R7 R11";
      3'd2:    return "R2";
      default: return "R10";
    endcase
  endfunction

  task automatic model_reset();
    m_data = 8'h00; m_din = 8'h00; m_byte = 8'h00; m_ctl = 6'h0C;
    m_busy = 1; m_ack = 1; m_onl = 1; m_err = 1; m_tmo = 1;
    m_irq = 0; m_valid = 0;
  endtask

  // one bus cycle; sel=0 gives an idle cycle
  task automatic do_op(input bit sel, input bit we, input logic [2:0] a,
                       input logic [7:0] w, input string tag);
    logic [5:0] old_ctl;
    logic       fall;
    string      t;
    @(negedge clk);
    bus_sel = sel; bus_we = we; bus_addr = a; bus_wdata = w;
    #1;
    t = (tag == "") ? def_tag(a) : tag;
    if (sel && !we) chk(t, bus_rdata, exp_read(a));
    @(posedge clk);
    old_ctl = m_ctl;
    fall    = 1'b0;
    m_valid = 1'b0;
    if (old_ctl[5]) m_din = pin_din;
    if (sel && we && a == 3'd0) m_data = w;
    if (sel && we && a == 3'd2) begin
      if (!w[2]) begin
        m_busy = 1; m_ack = 1; m_onl = 1; m_err = 1; m_tmo = 0;
      end else if (w[3] && w[0]) begin
        m_busy = 0;
        if (!old_ctl[0]) begin m_valid = 1; m_byte = m_data; end
      end
      m_ctl = w[5:0];
    end
    if (sel && !we && a == 3'd1 && !m_busy && !old_ctl[0]) begin
      if (m_ack) begin m_ack = 0; fall = 1; end
      else begin m_ack = 1; m_busy = 1; end
    end
    if (fall && old_ctl[4]) m_irq = 1;
    else if ((sel && !we && a == 3'd1) || !m_ctl[4]) m_irq = 0;
    #1;
    bus_sel = 1'b0;
    chk((tag == "") ? "R9" : tag, {7'd0, irq}, {7'd0, m_irq});
    chk((tag == "") ? "R5" : tag, {7'd0, prn_valid}, {7'd0, m_valid});
    if (m_valid) chk("R5", prn_byte, m_byte);
    chk("R2", pin_dout, m_data);
    chk("R2", {7'd0, pin_dout_en}, {7'd0, ~m_ctl[5]});
  endtask

  task automatic rd(input logic [2:0] a, input string tag);
    do_op(1'b1, 1'b0, a, 8'h00, tag);
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] w, input string tag);
    do_op(1'b1, 1'b1, a, w, tag);
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 200000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

  initial begin : main
    logic [7:0] v;
    int unsigned seed;
    seed = 32'd20240611;
    v = 8'($urandom(seed));
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state
    chk("R1", {7'd0, irq}, 8'd0);
    chk("R1", {7'd0, prn_valid}, 8'd0);
    rd(3'd1, "R1");
    rd(3'd2, "R1");
    rd(3'd0, "R1");

    // R10: ignored writes, unused reads
    wr(3'd1, 8'h00, "R10");
    rd(3'd1, "R10");
    for (int k = 3; k < 8; k++) begin
      wr(3'(k), 8'h5A, "R10");
      rd(3'(k), "R10");
    end
    rd(3'd2, "R10");
    rd(3'd0, "R10");

    // R11: paper-out input
    paper_out_in = 1'b1;
    rd(3'd1, "R11");
    paper_out_in = 1'b0;

    // R2: data and control write/readback
    wr(3'd0, 8'hA5, "R2");
    rd(3'd0, "R2");
    wr(3'd2, 8'hFF, "R2");
    rd(3'd2, "R2");

    // R3: input direction
    pin_din = 8'h3C;
    do_op(1'b0, 1'b0, 3'd0, 8'h00, "R3");
    rd(3'd0, "R3");

    // R4: init clear forces status
    wr(3'd2, 8'h18, "R4");
    rd(3'd1, "R4");

    // R5: strobe rising emits, then busy clear
    wr(3'd0, 8'h77, "R5");
    wr(3'd2, 8'h1C, "R5");
    wr(3'd2, 8'h1D, "R5");
    wr(3'd2, 8'h1D, "R5");
    rd(3'd1, "R5");

    // R8: poll with strobe high does nothing
    rd(3'd1, "R8");
    // R6: strobe rise with select clear
    wr(3'd2, 8'h14, "R6");
    wr(3'd2, 8'h15, "R6");
    rd(3'd1, "R6");

    // R7 and R9: handshake with interrupt enable
    wr(3'd2, 8'h1C, "R7");
    rd(3'd1, "R7 R9");
    rd(3'd1, "R7 R9");
    rd(3'd1, "R8");
    // R9: interrupt dropped by clearing the enable
    wr(3'd2, 8'h1D, "R9");
    wr(3'd2, 8'h1C, "R9");
    rd(3'd1, "R9");
    wr(3'd2, 8'h0C, "R9");
    rd(3'd1, "R9");

    // random mix
    for (int i = 0; i < N_RANDOM; i++) begin
      int op;
      op = int'($urandom % 10);
      if (($urandom % 4) == 0) pin_din = 8'($urandom);
      if (($urandom % 50) == 0) paper_out_in = ~paper_out_in;
      case (op)
        0, 1, 2: rd(3'd1, "");
        3:       rd(3'd0, "");
        4:       rd(3'd2, "");
        5:       wr(3'd0, 8'($urandom), "");
        6, 7: begin
          v = 8'($urandom);
          if (($urandom % 6) != 0) v[2] = 1'b1;
          if (($urandom % 5) != 0) v[3] = 1'b1;
          if (($urandom % 3) != 0) v[5] = 1'b0;
          wr(3'd2, v, "");
        end
        8: begin
          if ($urandom % 2) wr(3'(3 + ($urandom % 5)), 8'($urandom), "");
          else rd(3'(3 + ($urandom % 5)), "");
        end
        default: do_op(1'b0, 1'b0, 3'd0, 8'h00, "");
      endcase
    end

    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end
endmodule